// File: doc/BRIEF.md
# Multi-CPU Interrupt Router

This block collects system interrupt sources and per-processor interrupt requests and turns them into prioritized interrupt level lines for a small group of processors. One system register bank holds a sampled vector of pending system sources, a disable mask and a target-processor field. Each system source is translated into a processor interrupt level by a fixed mapping. The enabled sources are delivered as hard interrupts to the single selected target processor only. One bit of the disable mask acts as a global gate for those hard interrupts.

Every processor also has its own register bank. Its pending word holds software interrupt bits in the upper half and a level-15 request bit. Software sets and clears these bits through separate write offsets. A per-processor timer input is sampled into a timer pending bit. Software bits always reach the level lines. The level-15 bit and the timer bit are blocked while the global gate is closed.

Software reaches both banks through a simple 32-bit bus. A request is qualified by a valid strobe, and read data comes back one cycle later. The level outputs are registered.

Top module: `intr_route_top`

## Requirements
- R1: After reset all level outputs are 0. The system pending, mask and target reads and every processor pending read return 0. The mask holds the complement of the valid-source mask 0x0FFF_FFFF, so the global gate (mask bit 31) is closed.
- R2: Writing a processor's set offset (+0x08) ORs the written bits into its pending word, and writing its clear offset (+0x04) clears the written bits. Only bits 31:15 are stored. Written bits 14:0 have no effect.
- R3: Writing system offset 0x08 sets the written bits in the disable mask, and writing system offset 0x0C clears them. A read of offset 0x04 returns the mask ANDed with 0x0FFF_FFFF, so the global gate bit 31 never shows.
- R4: Writing system offset 0x10 stores the written value ANDed with (NCPU-1) as the target processor, and a read of the same offset returns it.
- R5: A read of system offset 0x00 returns the sampled system sources, disabled ones included, with bit 31 forced to 0. Read data appears in the cycle after the read request and holds until the next read.
- R6: System source j maps to level (j mod 15)+1 for j < 27. Sources 27 to 30 map to no level. A source reaches a level line only when it is pending, its mask bit is clear and the global gate is open.
- R7: Hard interrupts reach only the target processor. A read of the target processor's pending word also shows, at bit L, every level L mapped from the raw system pending vector, whatever the mask says. Other processors show none.
- R8: Pending bit 15 drives level 15 and the timer bit (bit 14, which follows that processor's timer input) drives level 14, and only while the global gate is open.
- R9: Software bit k (17 to 31) drives level k-16 whatever the state of the global gate. Software bit 16 drives no line.
- R10: A register write or input change shows on the level lines exactly two clock edges after it is presented. The first edge updates the state and the second updates the output.
- R11: Address bits 7:5 pick the bank: 0 is the system bank and c+1 is processor c. Accesses to other regions, to write-only offsets and to non-word-aligned addresses read as 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sys_irq | input | 31 | System interrupt source levels, bits 30:0 |
| cpu_timer | input | NCPU | Per-processor timer request |
| cpu_level | output | NCPU*15 | Level L of processor c at bit c*15+L-1 |

## Verification
The routing function is driven with single sources, with several sources at once that mix a normal mapping, the level-15 mapping and a source that maps to no level, and with the same pattern after the target is moved. These separate a wrong mapping, delivery to the wrong processor, and a missing level-0 filter. The same sources are then tried with one mask bit set and with the global gate closed. This separates per-source masking, which leaves the raw pending visible, from global gating. Software, level-15 and timer bits are each tried with the gate open and closed, which tells the always-on path from the gated one.

// File: rtl/intr_route_pkg.sv
// Shared constants, register offsets and the source-to-level mapping
// for the multi-processor interrupt router.
package intr_route_pkg;

    localparam int          WORD_W     = 32;
    localparam int          NLVL       = 15;             // levels 1..15
    localparam int          GATE_BIT   = 31;             // global hard-interrupt gate
    localparam logic [31:0] VALID_SRC  = 32'h0FFF_FFFF;  // readable mask bits
    localparam int          LVL15_BIT  = 15;
    localparam int          TIMER_BIT  = 14;
    localparam logic [31:0] STORE_MASK = 32'hFFFF_8000;  // software-writable bits
    localparam int          NO_LVL_SRC = 27;             // first source without a level

    typedef enum logic [2:0] {
        SYS_PEND = 3'd0,
        SYS_MASK = 3'd1,
        SYS_MSET = 3'd2,
        SYS_MCLR = 3'd3,
        SYS_TGT  = 3'd4
    } sys_reg_e;

    typedef enum logic [2:0] {
        CPU_PEND = 3'd0,
        CPU_CLR  = 3'd1,
        CPU_SET  = 3'd2
    } cpu_reg_e;

    // Level reached by system source j; 0 means the source is never delivered.
    function automatic logic [3:0] src_level(input int j);
        if (j >= NO_LVL_SRC) return 4'd0;
        return 4'((j % NLVL) + 1);
    endfunction

endpackage

// File: rtl/intr_level_map.sv
// Folds a vector of system sources onto processor levels.
// Output bit L-1 is set when any source mapping to level L is set.
// Assumes NSRC <= 32; purely combinational.
module intr_level_map
    import intr_route_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] src,
    output logic [NLVL-1:0] lv
);

    // OR every source into the line of its mapped level.
    always_comb begin
        lv = '0;
        for (int j = 0; j < NSRC; j++) begin
            if (src[j] && src_level(j) != 4'd0)
                lv[int'(src_level(j)) - 1] = 1'b1;
        end
    end

endmodule

// File: rtl/intr_sys_bank.sv
// System register bank: sampled source vector, disable mask with
// set/clear write offsets, and the target-processor field.
// Assumes NCPU is a power of two and at least 2.
module intr_sys_bank
    import intr_route_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       wdata,
    input  logic [30:0]       sys_irq,
    output logic [31:0]       pend,
    output logic [31:0]       mask,
    output logic [TGT_W-1:0]  target,
    output logic [31:0]       rd_data
);

    // Sample the source levels every cycle; bit 31 is never a source.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= {1'b0, sys_irq};
    end

    // Disable mask: separate offsets set and clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= ~VALID_SRC;
        end else if (hit && wr) begin
            if (reg_sel == SYS_MSET)      mask <= mask | wdata;
            else if (reg_sel == SYS_MCLR) mask <= mask & ~wdata;
        end
    end

    // Target field keeps only the bits that index a processor.
    always_ff @(posedge clk) begin
        if (!rst_n)                               target <= '0;
        else if (hit && wr && reg_sel == SYS_TGT) target <= wdata[TGT_W-1:0];
    end

    // Read view of the bank; write-only offsets read as zero.
    always_comb begin
        rd_data = '0;
        if (hit) begin
            case (reg_sel)
                SYS_PEND: rd_data = pend & ~(32'h1 << GATE_BIT);
                SYS_MASK: rd_data = mask & VALID_SRC;
                SYS_TGT:  rd_data = 32'(target);
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/intr_cpu_bank.sv
// Per-processor bank: stored software and level-15 bits, sampled timer
// bit, pending read view and the registered level lines.
// Assumes hard_lv and raw_lv come from registered system state.
module intr_cpu_bank
    import intr_route_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            wr,
    input  logic [2:0]      reg_sel,
    input  logic [31:0]     wdata,
    input  logic            timer_in,
    input  logic            is_target,
    input  logic            gate_closed,
    input  logic [NLVL-1:0] hard_lv,
    input  logic [NLVL-1:0] raw_lv,
    output logic [NLVL-1:0] level_out,
    output logic [31:0]     rd_data
);

    logic [31:0]     stored;
    logic            timer_q;
    logic [NLVL-1:0] next_lv;
    logic [NLVL-1:0] gated_lv;

    // Software-visible pending bits, changed only by set/clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (hit && wr) begin
            if (reg_sel == CPU_SET)      stored <= stored | (wdata & STORE_MASK);
            else if (reg_sel == CPU_CLR) stored <= stored & ~(wdata & STORE_MASK);
        end
    end

    // Timer pending bit follows the timer input level.
    always_ff @(posedge clk) begin
        if (!rst_n) timer_q <= 1'b0;
        else        timer_q <= timer_in;
    end

    // Level-15 and timer requests, blocked while the global gate is closed.
    always_comb begin
        gated_lv = '0;
        if (!gate_closed) begin
            gated_lv[LVL15_BIT-1] = stored[LVL15_BIT];
            gated_lv[TIMER_BIT-1] = timer_q;
        end
    end

    // Combine software, gated local and steered hard requests.
    always_comb begin
        next_lv = stored[31:17] | gated_lv;
        if (is_target && !gate_closed) next_lv = next_lv | hard_lv;
    end

    // Registered level lines.
    always_ff @(posedge clk) begin
        if (!rst_n) level_out <= '0;
        else        level_out <= next_lv;
    end

    // Pending read view: stored bits, timer bit, and raw mapped levels when targeted.
    always_comb begin
        rd_data = '0;
        if (hit && reg_sel == CPU_PEND) begin
            rd_data = stored | (32'(timer_q) << TIMER_BIT);
            if (is_target) rd_data = rd_data | {16'h0, raw_lv, 1'b0};
        end
    end

endmodule

// File: rtl/intr_route_top.sv
// Multi-processor interrupt router top: address decode, source masking
// and level mapping, steering to the target processor, registered read data.
// Assumes NCPU is a power of two, 2 <= NCPU < 2**(ADDR_W-5).
module intr_route_top
    import intr_route_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [30:0]            sys_irq,
    input  logic [NCPU-1:0]        cpu_timer,
    output logic [NCPU*NLVL-1:0]   cpu_level
);

    localparam int RGN_W = ADDR_W - 5;
    localparam int TGT_W = $clog2(NCPU);

    logic [RGN_W-1:0] region;
    logic [2:0]       reg_sel;
    logic             aligned;
    logic             sys_hit;
    logic [31:0]      pend_q;
    logic [31:0]      mask_q;
    logic [TGT_W-1:0] target_q;
    logic [31:0]      sys_rd;
    logic [31:0]      eff_pend;
    logic [NLVL-1:0]  hard_lv;
    logic [NLVL-1:0]  raw_lv;
    logic [31:0]      cpu_rd [NCPU];
    logic [31:0]      rd_any;

    // Split the address into bank region and register offset.
    assign region  = bus_addr[ADDR_W-1:5];
    assign reg_sel = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sys_hit = aligned && (region == '0);

    intr_sys_bank #(
        .NCPU  (NCPU),
        .TGT_W (TGT_W)
    ) u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (sys_hit),
        .wr      (bus_valid && bus_write),
        .reg_sel (reg_sel),
        .wdata   (bus_wdata),
        .sys_irq (sys_irq),
        .pend    (pend_q),
        .mask    (mask_q),
        .target  (target_q),
        .rd_data (sys_rd)
    );

    // Sources that are pending and not disabled.
    assign eff_pend = pend_q & ~mask_q;

    intr_level_map #(.NSRC(32)) u_map_eff (
        .src (eff_pend),
        .lv  (hard_lv)
    );

    intr_level_map #(.NSRC(32)) u_map_raw (
        .src (pend_q),
        .lv  (raw_lv)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        intr_cpu_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit         (aligned && (region == RGN_W'(c + 1))),
            .wr          (bus_valid && bus_write),
            .reg_sel     (reg_sel),
            .wdata       (bus_wdata),
            .timer_in    (cpu_timer[c]),
            .is_target   (target_q == TGT_W'(c)),
            .gate_closed (mask_q[GATE_BIT]),
            .hard_lv     (hard_lv),
            .raw_lv      (raw_lv),
            .level_out   (cpu_level[c*NLVL +: NLVL]),
            .rd_data     (cpu_rd[c])
        );
    end

    // Merge the read views; only the addressed bank drives non-zero data.
    always_comb begin
        rd_any = sys_rd;
        for (int c = 0; c < NCPU; c++) rd_any = rd_any | cpu_rd[c];
    end

    // Read data register, loaded on every read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_any;
    end

endmodule

// File: rtl/intr_route_chk.sv
// Bus-to-state properties of the interrupt router, bound to the top.
module intr_route_chk #(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    parameter int TGT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       mask,
    input logic [TGT_W-1:0]  target
);

    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(16);

    logic wr_set, wr_clr, wr_tgt;
    assign wr_set = bus_valid && bus_write && bus_addr == A_MSET;
    assign wr_clr = bus_valid && bus_write && bus_addr == A_MCLR;
    assign wr_tgt = bus_valid && bus_write && bus_addr == A_TGT;

    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(bus_wdata)) == 32'h0));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(mask));

    p_target_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgt |=> (target == $past(bus_wdata[TGT_W-1:0])));

    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind intr_route_top intr_route_chk #(
    .NCPU   (NCPU),
    .ADDR_W (ADDR_W),
    .TGT_W  (TGT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask      (mask_q),
    .target    (target_q)
);

// File: tb/tb_intr_route_top.sv
module tb_intr_route_top;

    localparam int NCPU = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [30:0]      sys_irq = '0;
    logic [NCPU-1:0]  cpu_timer = '0;
    logic [NCPU*15-1:0] cpu_level;

    int n_chk = 0;
    int n_bad = 0;

    intr_route_top #(.NCPU(NCPU), .ADDR_W(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_irq   (sys_irq),
        .cpu_timer (cpu_timer),
        .cpu_level (cpu_level)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] lv(input int c, input int l);
        return 64'(1) << (c * 15 + l - 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        brd(a, d);
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 levels after reset", 64'(cpu_level), 64'h0);
        rchk("R1 system pending", 8'h00, 32'h0);
        rchk("R1 mask read", 8'h04, 32'h0);
        rchk("R1 target", 8'h10, 32'h0);
        rchk("R1 cpu0 pending", 8'h20, 32'h0);
        rchk("R1 cpu3 pending", 8'h80, 32'h0);
    endtask

    task automatic t_soft();
        bwr(8'h48, 32'h0002_0000); settle();
        chk("R9 soft bit17 -> level1 with gate closed", 64'(cpu_level), lv(1, 1));
        bwr(8'h48, 32'h0001_0000); settle();
        chk("R9 soft bit16 drives nothing", 64'(cpu_level), lv(1, 1));
        rchk("R2 set accumulates", 8'h40, 32'h0003_0000);
        bwr(8'h48, 32'h8000_0000); settle();
        chk("R9 soft bit31 -> level15", 64'(cpu_level), lv(1, 1) | lv(1, 15));
        bwr(8'h44, 32'h8003_0000); settle();
        chk("R2 clear removes levels", 64'(cpu_level), 64'h0);
        rchk("R2 clear empties pending", 8'h40, 32'h0);
        bwr(8'h48, 32'h0000_7FFF);
        rchk("R2 low write bits ignored", 8'h40, 32'h0);
    endtask

    task automatic t_lvl15();
        bwr(8'h28, 32'h0000_8000); settle();
        chk("R8 level15 blocked by closed gate", 64'(cpu_level), 64'h0);
        rchk("R8 level15 bit stored", 8'h20, 32'h0000_8000);
        bwr(8'h0C, 32'h8000_0000);
        chk("R10 no change one edge after write", 64'(cpu_level), 64'h0);
        settle();
        chk("R10 R8 level15 after second edge", 64'(cpu_level), lv(0, 15));
        bwr(8'h08, 32'h8000_0000); settle();
        chk("R8 closing gate drops level15", 64'(cpu_level), 64'h0);
        rchk("R3 gate bit hidden in mask read", 8'h04, 32'h0);
        bwr(8'h24, 32'h0000_8000);
    endtask

    task automatic t_timer();
        @(negedge clk); cpu_timer[2] = 1'b1;
        settle(); settle();
        chk("R8 timer blocked by closed gate", 64'(cpu_level), 64'h0);
        rchk("R8 timer pending bit14", 8'h60, 32'h0000_4000);
        bwr(8'h0C, 32'h8000_0000); settle();
        chk("R8 timer -> level14 with gate open", 64'(cpu_level), lv(2, 14));
        @(negedge clk); cpu_timer[2] = 1'b0;
        settle(); settle();
        chk("R8 timer released", 64'(cpu_level), 64'h0);
    endtask

    task automatic t_hard();
        @(negedge clk); sys_irq = 31'(1 << 3);
        @(negedge clk);
        chk("R10 source not yet visible", 64'(cpu_level), 64'h0);
        settle();
        chk("R6 R7 source3 -> cpu0 level4 only", 64'(cpu_level), lv(0, 4));
        rchk("R5 pending read", 8'h00, 32'h0000_0008);
        rchk("R7 target pending shows level4", 8'h20, 32'h0000_0010);
        rchk("R7 non-target pending empty", 8'h40, 32'h0);
        bwr(8'h10, 32'h0000_0006); settle();
        rchk("R4 target masked to 2", 8'h10, 32'h0000_0002);
        chk("R4 R7 delivery moves to cpu2", 64'(cpu_level), lv(2, 4));
        @(negedge clk); sys_irq = 31'((1 << 3) | (1 << 14) | (1 << 20) | (1 << 27));
        settle(); settle();
        chk("R6 mixed sources, 27 has no level", 64'(cpu_level), lv(2, 4) | lv(2, 6) | lv(2, 15));
        rchk("R7 cpu2 raw mapped view", 8'h60, 32'h0000_8050);
        bwr(8'h08, 32'h0000_0008); settle();
        chk("R6 masked source dropped", 64'(cpu_level), lv(2, 6) | lv(2, 15));
        rchk("R5 masked source still pending", 8'h00, 32'h0810_4008);
        rchk("R3 mask read", 8'h04, 32'h0000_0008);
        bwr(8'h0C, 32'h0000_0008); settle();
        chk("R6 unmasked source back", 64'(cpu_level), lv(2, 4) | lv(2, 6) | lv(2, 15));
        bwr(8'h08, 32'h8000_0000); settle();
        chk("R6 closed gate blocks hard", 64'(cpu_level), 64'h0);
        rchk("R7 raw view ignores gate", 8'h60, 32'h0000_8050);
        bwr(8'h0C, 32'h8000_0000);
        bwr(8'h10, 32'h0);
        @(negedge clk); sys_irq = '0;
        settle(); settle();
        chk("R6 all sources released", 64'(cpu_level), 64'h0);
    endtask

    task automatic t_mask();
        bwr(8'h08, 32'h00F0_0000);
        rchk("R3 disable bits", 8'h04, 32'h00F0_0000);
        bwr(8'h0C, 32'h0030_0000);
        rchk("R3 enable some bits", 8'h04, 32'h00C0_0000);
        bwr(8'h0C, 32'h00C0_0000);
        rchk("R3 enable rest", 8'h04, 32'h0);
    endtask

    task automatic t_region();
        bwr(8'hA8, 32'hFFFF_0000); settle();
        chk("R11 unmapped region write", 64'(cpu_level), 64'h0);
        bwr(8'h4A, 32'h0002_0000); settle();
        chk("R11 misaligned write ignored", 64'(cpu_level), 64'h0);
        rchk("R11 misaligned write left pending", 8'h40, 32'h0);
        rchk("R11 unmapped read", 8'hE0, 32'h0);
        rchk("R11 write-only offset reads 0", 8'h08, 32'h0);
        @(negedge clk); sys_irq = 31'h5;
        settle(); settle();
        rchk("R5 read data", 8'h00, 32'h0000_0005);
        @(negedge clk); sys_irq = '0;
        settle(); settle();
        chk("R5 read data holds", 64'(bus_rdata), 64'h5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_soft();
        t_lvl15();
        t_timer();
        t_hard();
        t_mask();
        t_region();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule